// File: doc/BRIEF.md
# Hybrid Priority Round-Robin Arbiter

This block decides, once per clock, which of three requesters may use one shared resource. Requester 0 is an urgent client that always wins when it asks. Requesters 1 and 2 form a fair pool. When the urgent client is quiet, the pool members take turns. A one-bit pointer remembers which pool member was served most recently, and that member yields at the next contested decision.

The decision is registered. Requests sampled at a rising edge appear as a one-hot grant vector just after that same edge. An optional valid flag marks cycles in which any grant is active. A parent block drives the request lines each cycle and steers the resource by the grant bits.

Top module: `hybrid_prio_rr_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant` is 000 and `grant_valid` is 0. After reset the pointer favours requester 1, so the first contest between requesters 1 and 2 goes to requester 1.
- R2: Requester 0 is mapped to `req[0]` and `grant[0]`. Whenever `req[0]` is sampled high, the next grant is 001, whatever `req[2:1]` is.
- R3: When `req[0]` is low and exactly one of requesters 1 and 2 asks, that requester is granted. Requester 1 gets `grant` = 010 and requester 2 gets `grant` = 100.
- R4: When `req[0]` is low and both `req[1]` and `req[2]` are high, the grant goes to whichever of the two was not the most recent pool grant.
- R5: While `req` is held at 110, grants alternate between 010 and 100 on every consecutive cycle.
- R6: A grant to requester 0 leaves the pool pointer unchanged. Only a grant to requester 1 or 2 moves it.
- R7: When `req` is 000, the next grant is 000 and the pool pointer holds its value.
- R8: `grant` never has more than one bit set. `grant_valid` is 1 exactly when `grant` is nonzero.
- R9: The grant is registered. A change on `req` has no effect on `grant` until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request lines: bit 0 urgent client, bits 1 and 2 pool clients |
| grant | output | 3 | Registered one-hot grant, or 000 when idle |
| grant_valid | output | 1 | High when any grant bit is set |

## Verification
Starting from reset each time, the bench applies every ordered sequence of three request patterns out of the eight possible values. This tells apart the urgent-client override, a lone pool requester, a contested pool whose pointer was set by an earlier cycle, and idle cycles that must hold the pointer. Directed runs then hold both pool lines high to expose alternation. Urgent-client bursts are placed between pool grants to show that the pointer does not move. Grant is also sampled before each edge to catch any combinational path from `req`.

// File: rtl/hpra_pkg.sv
package hpra_pkg;

    localparam int NUM_CLIENTS = 3;
    localparam int IDX_URGENT  = 0;
    localparam int IDX_POOL_A  = 1;
    localparam int IDX_POOL_B  = 2;

    typedef logic [NUM_CLIENTS-1:0] req_vec_t;
    typedef logic [NUM_CLIENTS-1:0] gnt_vec_t;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_URGENT = 2'd1,
        WIN_POOL_A = 2'd2,
        WIN_POOL_B = 2'd3
    } winner_e;

    typedef struct packed {
        winner_e  winner;
        logic     moves_ptr;
        logic     ptr_next;
    } decision_t;

    function automatic gnt_vec_t winner_to_onehot(input winner_e w);
        gnt_vec_t v;
        v = '0;
        case (w)
            WIN_URGENT: v[IDX_URGENT] = 1'b1;
            WIN_POOL_A: v[IDX_POOL_A] = 1'b1;
            WIN_POOL_B: v[IDX_POOL_B] = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic winner_e pool_pick(input logic a, input logic b,
                                          input logic favour_b);
        winner_e w;
        if (a && b)
            w = favour_b ? WIN_POOL_B : WIN_POOL_A;
        else if (a)
            w = WIN_POOL_A;
        else if (b)
            w = WIN_POOL_B;
        else
            w = WIN_NONE;
        return w;
    endfunction

endpackage

// File: rtl/hpra_select.sv
module hpra_select
    import hpra_pkg::*;
(
    input  req_vec_t  req,
    input  logic      favour_b,
    output decision_t dec
);
    winner_e pool_w;

    always_comb begin
        pool_w = pool_pick(req[IDX_POOL_A], req[IDX_POOL_B], favour_b);
        dec    = '{winner: WIN_NONE, moves_ptr: 1'b0, ptr_next: favour_b};
        if (req[IDX_URGENT]) begin
            dec.winner = WIN_URGENT;
        end else begin
            dec.winner = pool_w;
            case (pool_w)
                WIN_POOL_A: begin dec.moves_ptr = 1'b1; dec.ptr_next = 1'b1; end
                WIN_POOL_B: begin dec.moves_ptr = 1'b1; dec.ptr_next = 1'b0; end
                default:    begin dec.moves_ptr = 1'b0; dec.ptr_next = favour_b; end
            endcase
        end
    end
endmodule

// File: rtl/hpra_pool_ptr.sv
module hpra_pool_ptr
    import hpra_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output logic      favour_b
);
    always_ff @(posedge clk) begin
        if (rst)
            favour_b <= 1'b0;
        else if (dec.moves_ptr)
            favour_b <= dec.ptr_next;
    end
endmodule

// File: rtl/hpra_grant_reg.sv
module hpra_grant_reg
    import hpra_pkg::*;
#(
    parameter bit HAS_VALID = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output gnt_vec_t  grant,
    output logic      grant_valid
);
    always_ff @(posedge clk) begin
        if (rst)
            grant <= '0;
        else
            grant <= winner_to_onehot(dec.winner);
    end

    generate
        if (HAS_VALID) begin : g_valid
            logic valid_q;
            always_ff @(posedge clk) begin
                if (rst)
                    valid_q <= 1'b0;
                else
                    valid_q <= (dec.winner != WIN_NONE);
            end
            assign grant_valid = valid_q;
        end else begin : g_novalid
            assign grant_valid = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hybrid_prio_rr_arbiter.sv
module hybrid_prio_rr_arbiter
    import hpra_pkg::*;
#(
    parameter bit HAS_VALID = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] req,
    output logic [NUM_CLIENTS-1:0] grant,
    output logic                   grant_valid
);
    decision_t dec;
    logic      favour_b;

    hpra_select u_select (
        .req      (req),
        .favour_b (favour_b),
        .dec      (dec)
    );

    hpra_pool_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .favour_b (favour_b)
    );

    hpra_grant_reg #(.HAS_VALID(HAS_VALID)) u_greg (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .grant       (grant),
        .grant_valid (grant_valid)
    );
endmodule

// File: rtl/hpra_checker.sv
module hpra_checker
    import hpra_pkg::*;
#(
    parameter bit HAS_VALID = 1'b1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CLIENTS-1:0] req,
    input logic [NUM_CLIENTS-1:0] grant,
    input logic                   grant_valid
);
    AST_AFTER_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (grant == 3'b000)); // R1

    AST_URGENT_WINS: assert property (@(posedge clk) disable iff (rst)
        req[0] |=> (grant == 3'b001)); // R2

    AST_LONE_POOL_A: assert property (@(posedge clk) disable iff (rst)
        (req == 3'b010) |=> (grant == 3'b010)); // R3

    AST_LONE_POOL_B: assert property (@(posedge clk) disable iff (rst)
        (req == 3'b100) |=> (grant == 3'b100)); // R3

    AST_ALTERNATE_AB: assert property (@(posedge clk) disable iff (rst)
        (grant == 3'b010 && req == 3'b110) |=> (grant == 3'b100)); // R5

    AST_ALTERNATE_BA: assert property (@(posedge clk) disable iff (rst)
        (grant == 3'b100 && req == 3'b110) |=> (grant == 3'b010)); // R5

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req == 3'b000) |=> (grant == 3'b000)); // R7

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R8

    generate
        if (HAS_VALID) begin : g_vchk
            AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
                grant_valid == (grant != 3'b000)); // R8
        end
    endgenerate
endmodule

bind hybrid_prio_rr_arbiter hpra_checker #(.HAS_VALID(HAS_VALID)) u_hpra_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/tb_hybrid_prio_rr_arbiter.sv
`timescale 1ns/1ps
module tb_hybrid_prio_rr_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req = 3'b000;
    logic [2:0] grant;
    logic       grant_valid;

    int total = 0;
    int bad   = 0;

    logic       m_fav_b;
    logic [2:0] prev_exp;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    hybrid_prio_rr_arbiter dut (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [2:0] model_step(input logic [2:0] r);
        logic [2:0] e;
        if (r[0])               e = 3'b001;
        else if (r[1] && r[2])  e = m_fav_b ? 3'b100 : 3'b010;
        else if (r[1])          e = 3'b010;
        else if (r[2])          e = 3'b100;
        else                    e = 3'b000;
        if (e == 3'b010) m_fav_b = 1'b1;
        if (e == 3'b100) m_fav_b = 1'b0;
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] r);
        if (r[0])              return "R2";
        if (r[1] && r[2])      return "R4";
        if (r[1] || r[2])      return "R3";
        return "R7";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = 3'b000;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1 grant in reset", grant, 3'b000);
        check("R1 valid in reset", {2'b00, grant_valid}, 3'b000);
        @(negedge clk);
        rst = 1'b0;
        m_fav_b  = 1'b0;
        prev_exp = 3'b000;
    endtask

    task automatic apply(input logic [2:0] r, input string tag);
        logic [2:0] e;
        @(negedge clk);
        req = r;
        #1;
        check("R9 grant before edge", grant, prev_exp);
        e = model_step(r);
        @(posedge clk);
        #1;
        check(tag, grant, e);
        check("R8 valid", {2'b00, grant_valid}, {2'b00, (e != 3'b000)});
        total++;
        if ($countones(grant) > 1) begin
            bad++;
            $display("FAIL R8: got=%b expected=at most one bit", grant);
        end
        prev_exp = e;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_fav_b  = 1'b0;
        prev_exp = 3'b000;

        // R1: reset state and first contest to requester 1
        do_reset();
        apply(3'b110, "R1 first contest");

        // Exhaustive three-step sequences
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 8; c++) begin
                    do_reset();
                    apply(a[2:0], tag_of(a[2:0]));
                    apply(b[2:0], tag_of(b[2:0]));
                    apply(c[2:0], tag_of(c[2:0]));
                end
            end
        end

        // R5: continuous pool contention alternates
        do_reset();
        for (int i = 0; i < 10; i++)
            apply(3'b110, "R5 alternate");

        // R6: urgent bursts leave pointer intact
        do_reset();
        apply(3'b010, "R6 seed A");
        apply(3'b001, "R6 urgent");
        apply(3'b111, "R6 urgent over pool");
        apply(3'b101, "R6 urgent over B");
        apply(3'b110, "R6 contest after urgent");
        apply(3'b011, "R6 urgent");
        apply(3'b110, "R6 contest again");

        // R7: idle holds pointer
        do_reset();
        apply(3'b100, "R7 seed B");
        apply(3'b000, "R7 idle");
        apply(3'b000, "R7 idle");
        apply(3'b110, "R7 contest after idle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule